// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a synchronous host and an external asynchronous static RAM of 64K words by 16 bits. The memory has one shared data bus and separate active-low enables for the low and high byte. The host gives a one-cycle request that carries an address, write data, a two-bit byte mask and a write flag. The controller turns it into a timed sequence on the memory's active-low chip select, write strobe, output enable and byte enables. It drives the bus only while it owns it, and for reads it returns the sampled data with a one-cycle valid pulse.

A write runs in three phases: setup, strobe and hold. The write strobe is the only control that changes between them, so the strobe's rising edge is the edge that ends the write. Address and data stay unchanged across that edge. A read holds the memory in read mode for a set number of wait cycles and then samples the bus. Each phase length is a parameter in clock cycles. The integrator sets these lengths to cover the memory's access time and the board delays. Byte lanes that the mask leaves out are not enabled at the memory, and they read back as zero.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, busy and read-valid are low, the tri-state enable is low, and chip select, write strobe, output enable and both byte enables are high.
- R2: A request seen while busy is low is accepted, and busy is high from the next cycle. Busy lasts SETUP_CYC+STROBE_CYC+HOLD_CYC cycles for a write and READ_CYC cycles for a read. A request that arrives while busy is high is dropped and has no effect on memory.
- R3: In a write, chip select is low for exactly SETUP_CYC+STROBE_CYC+HOLD_CYC cycles. The write strobe is low for STROBE_CYC of those cycles. The strobe rises while chip select is still low, so it is the edge that ends the write.
- R4: Whenever chip select is low, the memory address and the data-out bus do not change. The tri-state enable is high from the first setup cycle to the last hold cycle of a write, and it was already high and chip select low in the cycle before the strobe falls.
- R5: Output enable is high in every cycle where the tri-state enable is high or the write strobe is low.
- R6: In a read, chip select and output enable are low and the write strobe is high for READ_CYC cycles. The bus is sampled at the clock edge that ends the last of these cycles.
- R7: Read-valid is high for one cycle, in the cycle right after the last read wait cycle, and busy is low in that cycle. Read data bits [7:0] carry the low lane when mask bit 0 is set, and bits [15:8] carry the high lane when mask bit 1 is set. A lane whose bit is clear reads as zero.
- R8: During an access the low-byte enable is low exactly when mask bit 0 is set, and the high-byte enable is low exactly when mask bit 1 is set.
- R9: A request with mask 2'b00 never pulls chip select low and never raises busy. If it is a read, read-valid rises in the next cycle with data zero.
- R10: Whenever chip select is high, both byte enables, the write strobe and output enable are high and the tri-state enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | One-cycle request strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte mask, bit 0 low byte, bit 1 high byte |
| host_busy | output | 1 | Access in progress; requests are dropped |
| host_rdata | output | 16 | Read data, unselected lanes zero |
| host_rvalid | output | 1 | One-cycle read data valid |
| mem_addr | output | 16 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low-byte enable, active low |
| mem_ub_n | output | 1 | High-byte enable, active low |
| mem_dout | output | 16 | Data to drive onto the shared bus |
| mem_dout_en | output | 1 | Tri-state enable for mem_dout |
| mem_din | input | 16 | Data read back from the shared bus |

## Verification
Assertions check the properties that must hold on every cycle. They cover the bus-ownership rule (output enable high while the controller drives or strobes), the deselected idle state, the address and data holding still under chip select, the strobe rising while chip select is still low, and read-valid appearing only when the controller is idle. Other behaviour can only be shown through scenarios. These are the exact phase lengths, the byte-lane merging and the zeroing of lanes left out of a read, dropped requests leaving memory untouched, and empty-mask requests. The bench runs them against a behavioural memory model, and that model drives filler data onto lanes that are not enabled.

// File: rtl/sram_lane_pkg.sv
// Shared types for the byte-lane SRAM controller.
package sram_lane_pkg;
    // Phase of one memory access.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_RDWAIT
    } phase_e;
endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that times one access phase.
// Assumes: load is pulsed on phase entry with (phase length - 1); expired
// is high while the count is zero.
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_byte_lanes.sv
// Per-lane enable decode and read-data capture.
// Assumes: mask is the byte mask of the access in progress; capture pulses
// once at the sampling edge of a read. Lanes outside the mask capture zero.
module sram_byte_lanes #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    localparam int DW    = LANE_W * LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             capture,
    input  logic [LANES-1:0] mask,
    input  logic [DW-1:0]    din,
    output logic [LANES-1:0] lane_n_d,
    output logic [DW-1:0]    rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] q;

        assign lane_n_d[g] = ~(active & mask[g]);

        // Capture this lane from the bus, or zero if it is not selected.
        always_ff @(posedge clk) begin
            if (!rst_n)       q <= '0;
            else if (capture) q <= mask[g] ? din[g*LANE_W +: LANE_W] : '0;
        end

        assign rdata[g*LANE_W +: LANE_W] = q;
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
// Synchronous controller for an asynchronous 16-bit SRAM with byte enables.
// Turns one-cycle host requests into setup/strobe/hold write sequences or
// wait-then-sample reads. All memory controls come from registers, so no
// combinational glitch reaches the strobes.
// Assumes: phase lengths (>= 1 cycle each) cover the memory's timing;
// mem_din is already synchronous to clk at the sampling edge.
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LANE_W     = 8,
    parameter int SETUP_CYC  = 1,
    parameter int STROBE_CYC = 2,
    parameter int HOLD_CYC   = 1,
    parameter int READ_CYC   = 3,
    localparam int LANES     = 2,
    localparam int DATA_W    = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [LANES-1:0]  host_be,
    output logic              host_busy,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din
);
    localparam int MAX_W   = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int MAX_R   = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
    localparam int MAX_CYC = (MAX_W > MAX_R) ? MAX_W : MAX_R;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] READ_LD   = CNT_W'(READ_CYC - 1);

    phase_e             phase_q, phase_d;
    logic               tmr_load, tmr_expired, cap;
    logic [CNT_W-1:0]   tmr_val;
    logic [LANES-1:0]   be_q, mask_d, lane_n_d;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               cs_n_q, we_n_q, oe_n_q, den_q, busy_q, rvalid_q;
    logic [LANES-1:0]   lane_n_q;
    logic               take;

    assign take   = host_req && (phase_q == PH_IDLE);
    assign mask_d = (phase_q == PH_IDLE) ? host_be : be_q;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_byte_lanes #(.LANE_W(LANE_W), .LANES(LANES)) u_lanes (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (phase_d != PH_IDLE),
        .capture  (cap),
        .mask     (mask_d),
        .din      (mem_din),
        .lane_n_d (lane_n_d),
        .rdata    (host_rdata)
    );

    // Next phase, timer reload and read-capture decision.
    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap      = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (host_req) begin
                    if (host_be == '0) begin
                        cap = !host_we;
                    end else if (host_we) begin
                        phase_d  = PH_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = SETUP_LD;
                    end else begin
                        phase_d  = PH_RDWAIT;
                        tmr_load = 1'b1;
                        tmr_val  = READ_LD;
                    end
                end
            end
            PH_SETUP: if (tmr_expired) begin
                phase_d  = PH_STROBE;
                tmr_load = 1'b1;
                tmr_val  = STROBE_LD;
            end
            PH_STROBE: if (tmr_expired) begin
                phase_d  = PH_HOLD;
                tmr_load = 1'b1;
                tmr_val  = HOLD_LD;
            end
            PH_HOLD: if (tmr_expired) phase_d = PH_IDLE;
            PH_RDWAIT: if (tmr_expired) begin
                cap     = 1'b1;
                phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // Latch the accepted request; it stays fixed for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (take) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
            be_q    <= host_be;
        end
    end

    // Phase register and registered control outputs decoded from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            cs_n_q   <= 1'b1;
            we_n_q   <= 1'b1;
            oe_n_q   <= 1'b1;
            den_q    <= 1'b0;
            lane_n_q <= '1;
            busy_q   <= 1'b0;
            rvalid_q <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            cs_n_q   <= (phase_d == PH_IDLE);
            we_n_q   <= (phase_d != PH_STROBE);
            oe_n_q   <= (phase_d != PH_RDWAIT);
            den_q    <= (phase_d == PH_SETUP) || (phase_d == PH_STROBE) ||
                        (phase_d == PH_HOLD);
            lane_n_q <= lane_n_d;
            busy_q   <= (phase_d != PH_IDLE);
            rvalid_q <= cap;
        end
    end

    assign host_busy   = busy_q;
    assign host_rvalid = rvalid_q;
    assign mem_addr    = addr_q;
    assign mem_dout    = wdata_q;
    assign mem_dout_en = den_q;
    assign mem_cs_n    = cs_n_q;
    assign mem_we_n    = we_n_q;
    assign mem_oe_n    = oe_n_q;
    assign mem_lb_n    = lane_n_q[0];
    assign mem_ub_n    = lane_n_q[LANES-1];

    // R3: the strobe ends the write while select and bus drive remain.
    p_strobe_ends_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_cs_n && mem_dout_en));

    // R4: bus already driven and chip selected before the strobe falls.
    p_setup_before_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(mem_dout_en) && !$past(mem_cs_n)));

    // R4: address and data hold still while the chip stays selected.
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));

    // R5: no output enable while the controller drives or strobes.
    p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dout_en || !mem_we_n) |-> mem_oe_n);

    // R6: a read keeps the strobe high under chip select.
    p_read_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_cs_n));

    // R7: read-valid only appears with the controller idle.
    p_rvalid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> (!host_busy && mem_cs_n));

    // R8: a selected access always enables at least one lane.
    p_lane_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !(mem_lb_n && mem_ub_n));

    // R10: deselected means every other control is inactive.
    p_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (mem_lb_n && mem_ub_n && mem_we_n && mem_oe_n && !mem_dout_en));
endmodule

// File: tb/sram_lane_ctrl_tb_top.sv
// Scoreboard bench: the driver pushes expected read data, a monitor pops it
// when read-valid rises; a behavioural memory model sits on the memory side.
module sram_lane_ctrl_tb_top;
    localparam int SC = 1, TC = 2, HC = 1, RC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        host_req = 1'b0, host_we = 1'b0;
    logic [15:0] host_addr = '0, host_wdata = '0;
    logic [1:0]  host_be = '0;
    logic        host_busy, host_rvalid;
    logic [15:0] host_rdata, mem_addr, mem_dout;
    logic [15:0] mem_din = 16'hA5A5;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dout_en;

    sram_lane_ctrl #(.SETUP_CYC(SC), .STROBE_CYC(TC), .HOLD_CYC(HC), .READ_CYC(RC)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .host_busy(host_busy), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
    );

    int errors = 0, checks = 0;
    logic [15:0] arr [256];
    logic [15:0] exp_mem [256];
    logic [15:0] exp_q [$];
    logic prev_we = 1'b1;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Memory model: writes at the strobe's rising edge, read data per lane.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_oe_n && (mem_dout_en || !mem_we_n))
                check(1'b0, "R5 contention", {mem_oe_n, mem_dout_en, mem_we_n}, 32'h3);
            if (!prev_we && mem_we_n) begin
                check(!mem_cs_n && mem_dout_en, "R3 strobe not first edge",
                      {mem_cs_n, mem_dout_en}, 32'h1);
                if (!mem_lb_n) arr[mem_addr[7:0]][7:0]  = mem_dout[7:0];
                if (!mem_ub_n) arr[mem_addr[7:0]][15:8] = mem_dout[15:8];
            end
        end
        prev_we = mem_we_n;
        mem_din[7:0]  = (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_lb_n)
                        ? arr[mem_addr[7:0]][7:0] : 8'hA5;
        mem_din[15:8] = (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_ub_n)
                        ? arr[mem_addr[7:0]][15:8] : 8'hA5;
    end

    // Scoreboard monitor: compare read data against the queued expectation (R7).
    always @(posedge clk) begin
        #2;
        if (rst_n && host_rvalid) begin
            if (exp_q.size() == 0) check(1'b0, "R7 unexpected rvalid", 1, 0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(host_rdata == e, "R7 read data", host_rdata, e);
            end
        end
    end

    // Driver: issue one request and measure the access it causes.
    task automatic access(input bit we, input logic [15:0] a, input logic [15:0] d,
                          input logic [1:0] be, input bit intrude,
                          output int nbusy, output int ncs, output int nwe, output int lane_bad);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d; host_be = be;
        if (we) begin
            if (be[0]) exp_mem[a[7:0]][7:0]  = d[7:0];
            if (be[1]) exp_mem[a[7:0]][15:8] = d[15:8];
        end else begin
            exp_q.push_back({be[1] ? exp_mem[a[7:0]][15:8] : 8'h00,
                             be[0] ? exp_mem[a[7:0]][7:0]  : 8'h00});
        end
        @(negedge clk);
        host_req = 1'b0;
        nbusy = 0; ncs = 0; nwe = 0; lane_bad = 0;
        for (int g = 0; g < 100 && host_busy; g++) begin
            host_req = intrude && (g == 0);
            host_wdata = ~d;
            nbusy++;
            if (!mem_cs_n) ncs++;
            if (!mem_we_n) nwe++;
            if (!mem_cs_n && ((mem_lb_n != !be[0]) || (mem_ub_n != !be[1]))) lane_bad++;
            @(negedge clk);
        end
        host_req = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [15:0] d,
                            input logic [1:0] be, input bit intrude);
        int nb, nc, nw, lb;
        bit any;
        any = (be != 2'b00);
        access(1'b1, a, d, be, intrude, nb, nc, nw, lb);
        check(nb == (any ? SC + TC + HC : 0), "R2 write busy length", nb, any ? SC + TC + HC : 0);
        check(nw == (any ? TC : 0), "R3 strobe length", nw, any ? TC : 0);
        check(nc == (any ? SC + TC + HC : 0), "R9 select length", nc, any ? SC + TC + HC : 0);
        check(lb == 0, "R8 lane enables", lb, 0);
        check(mem_cs_n && mem_lb_n && mem_ub_n && !mem_dout_en, "R10 idle deselect",
              {mem_cs_n, mem_lb_n, mem_ub_n, mem_dout_en}, 32'hE);
    endtask

    task automatic do_read(input logic [15:0] a, input logic [1:0] be);
        int nb, nc, nw, lb;
        bit any;
        any = (be != 2'b00);
        access(1'b0, a, 16'h0, be, 1'b0, nb, nc, nw, lb);
        check(nb == (any ? RC : 0), "R6 read busy length", nb, any ? RC : 0);
        check(nc == (any ? RC : 0), "R9 read select length", nc, any ? RC : 0);
        check(nw == 0 && lb == 0, "R8 read lanes/strobe", {nw[15:0], lb[15:0]}, 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            arr[i] = 16'(i * 16'h0301);
            exp_mem[i] = 16'(i * 16'h0301);
        end
        repeat (3) @(negedge clk);
        check(!host_busy && !host_rvalid && !mem_dout_en, "R1 reset outputs",
              {host_busy, host_rvalid, mem_dout_en}, 0);
        check(mem_cs_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n, "R1 reset strobes",
              {mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 32'h1F);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs_n && mem_we_n && mem_oe_n && !host_busy, "R1 after release",
              {mem_cs_n, mem_we_n, mem_oe_n, host_busy}, 32'hE);

        // Full-word write and read back.
        do_write(16'h0010, 16'h1234, 2'b11, 1'b0);
        do_read(16'h0010, 2'b11);
        // Byte-lane merges (R8), lane zeroing on partial reads (R7).
        do_write(16'h0020, 16'hABCD, 2'b11, 1'b0);
        do_write(16'h0020, 16'h0055, 2'b01, 1'b0);
        do_read(16'h0020, 2'b11);
        do_write(16'h0020, 16'h7700, 2'b10, 1'b0);
        do_read(16'h0020, 2'b10);
        do_read(16'h0020, 2'b01);
        // Empty mask: no access, memory untouched; empty read returns zero (R9).
        do_write(16'h0010, 16'hFFFF, 2'b00, 1'b0);
        do_read(16'h0010, 2'b11);
        do_read(16'h0010, 2'b00);
        do_read(16'h0011, 2'b00);
        // Request while busy is dropped (R2).
        do_write(16'h0030, 16'h1111, 2'b11, 1'b1);
        do_read(16'h0030, 2'b11);
        // Untouched location keeps its initial content.
        do_read(16'h0042, 2'b11);
        do_write(16'h00FF, 16'hC3C3, 2'b11, 1'b0);
        do_read(16'h00FF, 2'b11);

        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R7 missing rvalid", exp_q.size(), 0);
        finish_run();
    end
endmodule